// File: doc/BRIEF.md
# Coin Credit Controller with Registered Release

This block counts coins toward a fixed price and raises a one-bit release flag once the price has been paid. Credit moves in equal steps, five cents by default. A nickel strobe adds one step and a dime strobe adds two. The credit stops at the price level and stays there until a synchronous reset clears it.

The release flag comes straight from a flip-flop, with no gates after it. That register is loaded from logic that looks at the current credit and the coin strobes and works out whether the credit after the coming edge will be at the price level. The flag therefore rises on the same clock edge at which the credit register reaches the price. Its timing matches a flag decoded from the full-credit state, and it cannot glitch.

The coin strobes are single-cycle pulses that are already synchronised to the clock. If both strobes are high in the same cycle, the block counts them as one dime.

Top module: `vend_credit_fsm`

## Requirements
- R1: After a synchronous reset, `open_o` is 0 and the credit is zero. From there, two nickels leave `open_o` at 0 and a third nickel raises it.
- R2: A cycle with `nickel_i`=1 and `dime_i`=0 raises the credit by exactly one step (5 cents).
- R3: A cycle with `dime_i`=1 raises the credit by exactly two steps (10 cents). A dime followed by a nickel raises `open_o`, and so does a nickel followed by a dime.
- R4: A cycle with neither strobe high leaves the credit and `open_o` unchanged.
- R5: The credit saturates at the price (15 cents). Two dimes, or a dime that lands on 10 cents, give full credit and nothing beyond it.
- R6: Once `open_o` is 1, it stays 1 whatever coins arrive, until reset is asserted.
- R7: When `nickel_i` and `dime_i` are both high in one cycle, the block behaves exactly as if only a dime had arrived.
- R8: `open_o` changes only at a clock edge. It becomes 1 after the same edge that samples the coin that completes the price, and it equals "credit is at the price" in every cycle.
- R9: `rst`=1 at a clock edge clears the credit and `open_o`, from any state, even while coin strobes are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| nickel_i | input | 1 | One-cycle strobe: one step of credit |
| dime_i | input | 1 | One-cycle strobe: two steps of credit |
| open_o | output | 1 | Registered release flag, 1 while the credit is at the price |

## Verification
The credit is not visible at the ports. A wrong credit shows up as `open_o` rising one coin too early or too late, or never rising at all. Because the bench keeps its own model of the credit and compares `open_o` after every edge, a bad step size, a missed saturation or a mis-ordered simultaneous-coin case is caught within one to three coins of the fault. A predictor that disagrees with the credit register shows up as a one-cycle skew on `open_o`, and the bench reports it at the edge where the price is reached.

// File: rtl/vend_pkg.sv
package vend_pkg;

  typedef enum logic [1:0] {
    COIN_NONE   = 2'd0,
    COIN_NICKEL = 2'd1,
    COIN_DIME   = 2'd2
  } coin_e;

  // dime wins when both strobes are present
  function automatic coin_e coin_classify(input logic nickel, input logic dime);
    if (dime)        return COIN_DIME;
    else if (nickel) return COIN_NICKEL;
    else             return COIN_NONE;
  endfunction

  function automatic logic [1:0] coin_steps(input coin_e c);
    case (c)
      COIN_NICKEL: return 2'd1;
      COIN_DIME:   return 2'd2;
      default:     return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/vend_coin_decode.sv
module vend_coin_decode
  import vend_pkg::*;
(
  input  logic       nickel_i,
  input  logic       dime_i,
  output logic [1:0] steps_o
);
  coin_e coin;

  always_comb begin
    coin    = coin_classify(nickel_i, dime_i);
    steps_o = coin_steps(coin);
  end
endmodule

// File: rtl/vend_credit_next.sv
module vend_credit_next #(
  parameter int unsigned CW  = 2,
  parameter int unsigned TOP = 3
) (
  input  logic [CW-1:0] credit_i,
  input  logic [1:0]    steps_i,
  output logic [CW-1:0] credit_o
);
  localparam int unsigned SW = CW + 2;

  logic [SW-1:0] sum;

  always_comb begin
    sum = SW'(credit_i) + SW'(steps_i);
    if (sum >= SW'(TOP)) credit_o = CW'(TOP);
    else                 credit_o = sum[CW-1:0];
  end
endmodule

// File: rtl/vend_open_predict.sv
module vend_open_predict #(
  parameter int unsigned CW  = 2,
  parameter int unsigned TOP = 3
) (
  input  logic [CW-1:0] credit_i,
  input  logic [1:0]    steps_i,
  output logic          open_d_o
);
  localparam int unsigned SW = CW + 2;

  logic [SW-1:0] gap;

  always_comb begin
    gap      = SW'(TOP) - SW'(credit_i);
    open_d_o = (credit_i == CW'(TOP)) || (SW'(steps_i) >= gap);
  end
endmodule

// File: rtl/vend_credit_fsm.sv
module vend_credit_fsm #(
  parameter int unsigned STEP_CENTS  = 5,
  parameter int unsigned PRICE_CENTS = 15
) (
  input  logic clk,
  input  logic rst,
  input  logic nickel_i,
  input  logic dime_i,
  output logic open_o
);
  localparam int unsigned LEVELS = PRICE_CENTS / STEP_CENTS + 1;
  localparam int unsigned CW     = (LEVELS > 2) ? $clog2(LEVELS) : 1;
  localparam int unsigned TOP    = LEVELS - 1;

  logic [1:0]    steps;
  logic [CW-1:0] credit_q, credit_d;
  logic          open_q, open_d;

  vend_coin_decode u_decode (
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .steps_o  (steps)
  );

  vend_credit_next #(.CW(CW), .TOP(TOP)) u_next (
    .credit_i (credit_q),
    .steps_i  (steps),
    .credit_o (credit_d)
  );

  vend_open_predict #(.CW(CW), .TOP(TOP)) u_predict (
    .credit_i (credit_q),
    .steps_i  (steps),
    .open_d_o (open_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_q <= '0;
      open_q   <= 1'b0;
    end else begin
      credit_q <= credit_d;
      open_q   <= open_d;
    end
  end

  assign open_o = open_q;

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (credit_q == '0 && !open_q)); // R9
  AST_FLAG_TRACKS_CREDIT: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (open_q == (credit_q == CW'(TOP)))); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst) open_q |=> open_q); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!nickel_i && !dime_i) |=> ($stable(credit_q) && $stable(open_q))); // R4
  AST_NICKEL_STEP: assert property (@(posedge clk) disable iff (rst)
    (nickel_i && !dime_i && credit_q != CW'(TOP)) |=> (credit_q == $past(credit_q) + CW'(1))); // R2
  AST_DIME_STEP: assert property (@(posedge clk) disable iff (rst)
    (dime_i && credit_q < CW'(TOP - 1)) |=> (credit_q == $past(credit_q) + CW'(2))); // R3
  AST_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (dime_i && credit_q >= CW'(TOP - 1)) |=> (credit_q == CW'(TOP))); // R5
endmodule

// File: tb/vend_credit_fsm_bench.sv
module vend_credit_fsm_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic nickel_i = 1'b0;
  logic dime_i = 1'b0;
  logic open_o;

  int vectors = 0;
  int errors  = 0;
  int credit  = 0;   // reference model, in steps of 5 cents
  bit done    = 0;

  always #5 clk = ~clk;

  vend_credit_fsm u_vend_credit_fsm (
    .clk      (clk),
    .rst      (rst),
    .nickel_i (nickel_i),
    .dime_i   (dime_i),
    .open_o   (open_o)
  );

  task automatic step(input bit n, input bit d, input bit r, input string tag);
    bit exp_open;
    @(negedge clk);
    nickel_i = n; dime_i = d; rst = r;
    @(posedge clk);
    if (r) credit = 0;
    else if (credit < 3) begin
      credit = credit + (d ? 2 : (n ? 1 : 0));   // R7: dime wins
      if (credit > 3) credit = 3;                // R5
    end
    exp_open = (credit == 3);
    #1;
    vectors++;
    if (open_o !== exp_open) begin
      errors++;
      $display("FAIL %s: open_o=%b expected %b (n=%b d=%b r=%b)", tag, open_o, exp_open, n, d, r);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, got 0 expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    int unsigned lfsr = 32'h1ACE_5EED;
    step(0, 0, 1, "R9 reset");
    step(0, 0, 1, "R1 reset state");
    step(0, 0, 0, "R1 idle after reset");
    step(1, 0, 0, "R1 R2 nickel 1");
    step(1, 0, 0, "R2 nickel 2");
    step(0, 0, 0, "R4 idle at 10");
    step(1, 0, 0, "R2 R8 nickel 3 opens");
    step(0, 0, 0, "R6 hold open");
    step(1, 0, 0, "R6 nickel while open");
    step(0, 1, 0, "R6 dime while open");
    step(1, 1, 1, "R9 reset with coins");
    step(0, 1, 0, "R3 dime first");
    step(0, 0, 0, "R4 idle at 10");
    step(1, 0, 0, "R3 nickel completes");
    step(0, 0, 1, "R9 reset");
    step(1, 0, 0, "R3 nickel first");
    step(0, 1, 0, "R3 R8 dime completes");
    step(0, 0, 1, "R9 reset");
    step(0, 1, 0, "R5 dime one");
    step(0, 1, 0, "R5 dime two saturates");
    step(0, 0, 0, "R5 saturated hold");
    step(0, 0, 1, "R9 reset");
    step(1, 1, 0, "R7 both strobes");
    step(0, 0, 0, "R7 still at 10");
    step(1, 0, 0, "R7 nickel completes");
    step(0, 0, 1, "R9 reset");
    step(1, 0, 0, "R5 nickel");
    step(1, 0, 0, "R5 nickel");
    step(1, 1, 0, "R5 R7 both at 10");
    step(0, 0, 1, "R9 reset");
    step(1, 1, 0, "R7 both");
    step(1, 1, 0, "R7 R5 both again");
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step(lfsr[0], lfsr[1] & lfsr[2], (lfsr[7:3] == 5'd0), "R8 random stream");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule